// File: doc/BRIEF.md
# External Horizontal Reference Extractor

This block derives a line-rate reference pulse, `ref_h`, from an external video timing source so that an outside phase-locked loop can compare it against the locally generated line pulse. It also produces a one-clock vertical reset strobe, `vreset_strobe`, that restarts the local field timing. The loop filter, oscillator and phase comparator are outside the block.

Two sources are supported and chosen by `sel_composite`. With separate drives, `ref_h` is a registered copy of the horizontal drive input, and each falling edge of the vertical drive input yields one strobe. With composite sync, every accepted falling edge of the sync input pulls `ref_h` low, and a local clock counter regenerates the rising edge a fixed number of clocks later. The external loop therefore compares falling edges in this mode. The counter ignores any fall that arrives while it runs. This keeps equalising pulses at half-line spacing from retriggering it. A vertical interval is recognised when the sync input stays low for a parameterised number of clocks, longer than any normal line pulse. Only one strobe is issued per interval. The detector re-arms after the input has stayed high for a second, longer threshold.

All inputs, the mode select included, are asynchronous to the local pixel clock and pass through a two-flop synchroniser. Both source paths run at all times, and the synchronised mode picks which one reaches the outputs.

Top module: `hsync_ref_extract`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ref_h` becomes 1 and `vreset_strobe` becomes 0.
- R2: The mode select passes through the two-flop synchroniser. A synchronised value of 1 selects composite-sync operation, and 0 selects separate-drive operation, for both outputs.
- R3: In separate-drive mode, the level of `ext_hd` sampled at clock edge n appears on `ref_h` after edge n+2. Rising and falling edges are both copied.
- R4: In composite mode, when `ext_csync` is sampled 1 at edge n-1 and 0 at edge n while the rise counter is idle, `ref_h` goes low after edge n+2.
- R5: In composite mode, `ref_h` returns high exactly RISE_DELAY (default 42) clocks after the edge at which it fell.
- R6: In composite mode, a falling edge of `ext_csync` that arrives while the rise counter is running has no effect on `ref_h`.
- R7: In separate-drive mode, each falling edge of `ext_vd` (1 at edge n-1, 0 at edge n) raises `vreset_strobe` after edge n+2.
- R8: In composite mode, `vreset_strobe` is raised after edge n+2 when `ext_csync` has been sampled 0 on VS_THRESH consecutive edges ending at edge n, and the detector is armed.
- R9: In composite mode, at most one strobe is issued per vertical interval. The detector re-arms only after `ext_csync` has been sampled 1 on REARM_THRESH consecutive edges.
- R10: `vreset_strobe` is never high on two consecutive clocks while the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_composite | input | 1 | Source select, asynchronous: 1 composite sync, 0 separate drives |
| ext_hd | input | 1 | External horizontal drive, asynchronous |
| ext_vd | input | 1 | External vertical drive, asynchronous |
| ext_csync | input | 1 | External composite sync, asynchronous |
| ref_h | output | 1 | Line-rate reference pulse for the external phase comparator |
| vreset_strobe | output | 1 | One-clock vertical reset strobe |

## Verification
The assertions check several properties on every cycle. These are the two-clock latency of the horizontal copy and the exact low width of the regenerated composite pulse. They also check that each strobe is preceded at the ports by the input condition that must cause it, and that strobes are always single-clock. Only the bench's scenarios show certain other behaviours. One is that a fall during the rise count is ignored. Another is that a full sequence of equalising and broad pulses yields exactly one strobe per field and re-arms on the following normal lines. A third is that a mode change moves both outputs to the other source.

// File: rtl/hre_pkg.sv
// Package hre_pkg
// Shared types and helpers for the external horizontal reference extractor.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package hre_pkg;

    // Source selection as seen after synchronisation
    typedef enum logic {
        SRC_SEPARATE  = 1'b0,
        SRC_COMPOSITE = 1'b1
    } src_sel_t;

    // Bit positions of the bundled asynchronous inputs
    localparam int unsigned IN_HD    = 0;
    localparam int unsigned IN_VD    = 1;
    localparam int unsigned IN_CSYNC = 2;
    localparam int unsigned IN_MODE  = 3;
    localparam int unsigned IN_COUNT = 4;

    // Largest of three counts, used to size shared counters
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/hre_sync.sv
// Module hre_sync
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Each bit passes through STAGES flops. On reset every stage loads RESET_VAL
// so that no false edge is seen when reset is released.
// Assumes the bits are independent and need no mutual coherence.
module hre_sync #(
    parameter int unsigned     WIDTH     = 4,
    parameter int unsigned     STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        genvar s;
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture of the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Further resolution stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/hre_hdvd_path.sv
// Module hre_hdvd_path
// Separate-drive source path: registers the synchronised horizontal drive
// as the reference, and turns each falling edge of the synchronised
// vertical drive into a one-clock strobe.
// Assumes hd_s and vd_s come from a synchroniser that resets them high.
module hre_hdvd_path (
    input  logic clk,
    input  logic rst_n,
    input  logic hd_s,
    input  logic vd_s,
    output logic ref_hd,
    output logic vs_hd
);

    logic vd_prev;
    logic vd_fall;

    // Remember the previous vertical drive level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) vd_prev <= 1'b1;
        else        vd_prev <= vd_s;
    end

    assign vd_fall = vd_prev & ~vd_s;

    // Register the horizontal copy and the vertical strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_hd <= 1'b1;
            vs_hd  <= 1'b0;
        end else begin
            ref_hd <= hd_s;
            vs_hd  <= vd_fall;
        end
    end

endmodule

// File: rtl/hre_rise_regen.sv
// Module hre_rise_regen
// Composite-sync horizontal reference. An accepted falling edge of the
// synchronised sync input drives the reference low and starts a counter.
// The reference rises again RISE_DELAY clocks later. Falls seen while the
// counter runs are ignored.
// Assumes RISE_DELAY >= 2 and cs_fall is a single-cycle pulse.
module hre_rise_regen #(
    parameter int unsigned RISE_DELAY = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    output logic ref_cs
);

    localparam int unsigned CNT_W  = $clog2(RISE_DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RISE_DELAY - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    // Start, run and finish the rise-delay count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            ref_cs <= 1'b1;
        end else if (!busy) begin
            if (cs_fall) begin
                busy   <= 1'b1;
                cnt    <= '0;
                ref_cs <= 1'b0;
            end
        end else if (cnt == LAST) begin
            busy   <= 1'b0;
            ref_cs <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hre_vert_sep.sv
// Module hre_vert_sep
// Composite-sync vertical separator. Counts consecutive low and high
// samples of the synchronised sync input. A low run of VS_THRESH samples
// while armed yields one strobe and disarms. A high run of REARM_THRESH
// samples re-arms the detector.
// Assumes VS_THRESH exceeds any normal line pulse and REARM_THRESH
// exceeds the high time between half-line pulses.
module hre_vert_sep #(
    parameter int unsigned VS_THRESH    = 400,
    parameter int unsigned REARM_THRESH = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    output logic vs_cs
);

    localparam int unsigned CNT_W =
        $clog2(((VS_THRESH > REARM_THRESH) ? VS_THRESH : REARM_THRESH) + 1);
    localparam logic [CNT_W-1:0] LOW_HIT  = CNT_W'(VS_THRESH - 1);
    localparam logic [CNT_W-1:0] LOW_SAT  = CNT_W'(VS_THRESH);
    localparam logic [CNT_W-1:0] HIGH_HIT = CNT_W'(REARM_THRESH - 1);
    localparam logic [CNT_W-1:0] HIGH_SAT = CNT_W'(REARM_THRESH);

    logic [CNT_W-1:0] low_run;
    logic [CNT_W-1:0] high_run;
    logic             armed;
    logic             low_hit;
    logic             high_hit;

    assign low_hit  = ~cs_s & (low_run == LOW_HIT);
    assign high_hit =  cs_s & (high_run == HIGH_HIT);

    // Saturating run-length counters for each input level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '0;
        end else if (!cs_s) begin
            high_run <= '0;
            if (low_run != LOW_SAT) low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
            if (high_run != HIGH_SAT) high_run <= high_run + 1'b1;
        end
    end

    // Arm, fire once and re-arm the vertical detector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            vs_cs <= 1'b0;
        end else begin
            vs_cs <= low_hit & armed;
            if (low_hit & armed) armed <= 1'b0;
            else if (high_hit)   armed <= 1'b1;
        end
    end

endmodule

// File: rtl/hsync_ref_extract.sv
// Module hsync_ref_extract (top)
// Derives a line-rate reference and a vertical reset strobe from either
// separate horizontal/vertical drives or a composite sync input. All inputs
// are synchronised to clk. Both source paths run continuously, and the
// synchronised mode select chooses which one drives the outputs.
// Assumes inputs idle high and the reset is synchronous and active low.
module hsync_ref_extract
    import hre_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned RISE_DELAY   = 42,
    parameter int unsigned VS_THRESH    = 400,
    parameter int unsigned REARM_THRESH = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_composite,
    input  logic ext_hd,
    input  logic ext_vd,
    input  logic ext_csync,
    output logic ref_h,
    output logic vreset_strobe
);

    localparam logic [IN_COUNT-1:0] IN_RESET = IN_COUNT'(4'b0111);

    logic [IN_COUNT-1:0] raw_in;
    logic [IN_COUNT-1:0] syn_in;
    src_sel_t            mode_s;
    logic                cs_prev;
    logic                cs_fall;
    logic                ref_hd;
    logic                vs_hd;
    logic                ref_cs;
    logic                vs_cs;

    // Bundle the asynchronous inputs in package-defined order
    always_comb begin
        raw_in           = '0;
        raw_in[IN_HD]    = ext_hd;
        raw_in[IN_VD]    = ext_vd;
        raw_in[IN_CSYNC] = ext_csync;
        raw_in[IN_MODE]  = sel_composite;
    end

    hre_sync #(
        .WIDTH     (IN_COUNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IN_RESET)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (syn_in)
    );

    assign mode_s = src_sel_t'(syn_in[IN_MODE]);

    // Previous composite sync level for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= syn_in[IN_CSYNC];
    end

    assign cs_fall = cs_prev & ~syn_in[IN_CSYNC];

    hre_hdvd_path u_hdvd (
        .clk    (clk),
        .rst_n  (rst_n),
        .hd_s   (syn_in[IN_HD]),
        .vd_s   (syn_in[IN_VD]),
        .ref_hd (ref_hd),
        .vs_hd  (vs_hd)
    );

    hre_rise_regen #(
        .RISE_DELAY (RISE_DELAY)
    ) u_regen (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_fall (cs_fall),
        .ref_cs  (ref_cs)
    );

    hre_vert_sep #(
        .VS_THRESH    (VS_THRESH),
        .REARM_THRESH (REARM_THRESH)
    ) u_vsep (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_s  (syn_in[IN_CSYNC]),
        .vs_cs (vs_cs)
    );

    // Route the selected source to the outputs
    always_comb begin
        if (mode_s == SRC_COMPOSITE) begin
            ref_h         = ref_cs;
            vreset_strobe = vs_cs;
        end else begin
            ref_h         = ref_hd;
            vreset_strobe = vs_hd;
        end
    end

endmodule

// File: rtl/hsync_ref_extract_chk.sv
// Module hsync_ref_extract_chk
// Property checker bound to hsync_ref_extract. Relates ports over time
// and watches the composite pulse width with a counter. Assumes two
// synchroniser stages, matching the default of the top module.
module hsync_ref_extract_chk #(
    parameter int unsigned RISE_DELAY = 42
) (
    input logic clk,
    input logic rst_n,
    input logic sel_composite,
    input logic ext_hd,
    input logic ext_vd,
    input logic ext_csync,
    input logic ref_h,
    input logic ref_cs,
    input logic vs_cs,
    input logic vs_hd
);

    logic [2:0]  up_cnt;
    logic [15:0] low_len;
    logic        settled;

    // Count edges since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            up_cnt <= '0;
        else if (up_cnt != 3'd7) up_cnt <= up_cnt + 1'b1;
    end

    // Measure how long the composite reference has been low
    always_ff @(posedge clk) begin
        if (!rst_n)      low_len <= '0;
        else if (!ref_cs) low_len <= low_len + 1'b1;
        else             low_len <= '0;
    end

    assign settled = (up_cnt >= 3'd5);

    AST_HD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !$past(sel_composite, 2)) |-> (ref_h == $past(ext_hd, 3))); // R3

    AST_RISE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $rose(ref_cs)) |-> (low_len == 16'(RISE_DELAY))); // R5

    AST_HD_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && vs_hd) |-> (!$past(ext_vd, 3) && $past(ext_vd, 4))); // R7

    AST_CS_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && vs_cs) |-> !$past(ext_csync, 3)); // R8

    AST_HD_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vs_hd |=> !vs_hd); // R10

    AST_CS_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vs_cs |=> !vs_cs); // R10

endmodule

bind hsync_ref_extract hsync_ref_extract_chk #(
    .RISE_DELAY (RISE_DELAY)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_composite (sel_composite),
    .ext_hd        (ext_hd),
    .ext_vd        (ext_vd),
    .ext_csync     (ext_csync),
    .ref_h         (ref_h),
    .ref_cs        (ref_cs),
    .vs_cs         (vs_cs),
    .vs_hd         (vs_hd)
);

// File: tb/hsync_ref_extract_test.sv
// Bench for hsync_ref_extract: a behavioural reference model compared on
// every clock, plus directed scenario checks.
module hsync_ref_extract_test;

    localparam int RD = 42;
    localparam int VS = 24;
    localparam int RE = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_composite = 1'b0;
    logic ext_hd = 1'b1;
    logic ext_vd = 1'b1;
    logic ext_csync = 1'b1;
    logic ref_h;
    logic vreset_strobe;

    int n_checks = 0;
    int n_fail = 0;
    bit compare_on = 1'b0;
    string ref_tag = "R3";

    always #10 clk = ~clk;

    hsync_ref_extract #(
        .RISE_DELAY   (RD),
        .VS_THRESH    (VS),
        .REARM_THRESH (RE)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_composite (sel_composite),
        .ext_hd        (ext_hd),
        .ext_vd        (ext_vd),
        .ext_csync     (ext_csync),
        .ref_h         (ref_h),
        .vreset_strobe (vreset_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: input histories and behavioural state
    bit hd_h[$], vd_h[$], cs_h[$], md_h[$];
    bit m_ref_hd, m_vs_hd, m_ref_cs, m_vs_cs, m_busy, m_armed;
    int m_cnt, m_low, m_hi;

    function automatic void model_reset();
        hd_h = '{1, 1, 1}; vd_h = '{1, 1, 1}; cs_h = '{1, 1, 1}; md_h = '{0, 0, 0};
        m_ref_hd = 1; m_vs_hd = 0; m_ref_cs = 1; m_vs_cs = 0;
        m_busy = 0; m_armed = 1; m_cnt = 0; m_low = 0; m_hi = 0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            // index 1 holds the sample two edges back, index 2 three back
            m_ref_hd = hd_h[1];
            m_vs_hd  = vd_h[2] && !vd_h[1];
            m_vs_cs  = 0;
            if (!cs_h[1]) begin
                if (m_armed && m_low == VS - 1) begin m_vs_cs = 1; m_armed = 0; end
                if (m_low < VS) m_low++;
                m_hi = 0;
            end else begin
                if (m_hi == RE - 1) m_armed = 1;
                if (m_hi < RE) m_hi++;
                m_low = 0;
            end
            if (!m_busy) begin
                if (cs_h[2] && !cs_h[1]) begin m_busy = 1; m_cnt = 0; m_ref_cs = 0; end
            end else if (m_cnt == RD - 1) begin
                m_busy = 0; m_ref_cs = 1;
            end else m_cnt++;
            hd_h.push_front(ext_hd); void'(hd_h.pop_back());
            vd_h.push_front(ext_vd); void'(vd_h.pop_back());
            cs_h.push_front(ext_csync); void'(cs_h.pop_back());
            md_h.push_front(sel_composite); void'(md_h.pop_back());
        end
    end

    // Per-clock comparison and scenario monitors
    int strobe_cnt = 0;
    int strobe_run = 0;
    int max_strobe_run = 0;
    int low_run = 0;
    int last_low_run = 0;

    always @(negedge clk) begin
        bit mode;
        mode = md_h[1];
        if (compare_on) begin
            check(ref_h == (mode ? m_ref_cs : m_ref_hd), ref_tag, ref_h,
                  mode ? m_ref_cs : m_ref_hd);
            check(vreset_strobe == (mode ? m_vs_cs : m_vs_hd), mode ? "R8" : "R7",
                  vreset_strobe, mode ? m_vs_cs : m_vs_hd);
        end
        if (vreset_strobe) begin
            if (strobe_run == 0) strobe_cnt++;
            strobe_run++;
            if (strobe_run > max_strobe_run) max_strobe_run = strobe_run;
        end else strobe_run = 0;
        if (!ref_h) low_run++;
        else begin
            if (low_run != 0) last_low_run = low_run;
            low_run = 0;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cs_pulse(input int low_len, input int high_len);
        ext_csync = 1'b0; cycles(low_len);
        ext_csync = 1'b1; cycles(high_len);
    endtask

    task automatic hd_pulse(input int low_len, input int high_len);
        ext_hd = 1'b0; cycles(low_len);
        ext_hd = 1'b1; cycles(high_len);
    endtask

    task automatic field();
        for (int i = 0; i < 6; i++) cs_pulse(3, 37);
        for (int i = 0; i < 6; i++) cs_pulse(34, 6);
        for (int i = 0; i < 6; i++) cs_pulse(3, 37);
        for (int i = 0; i < 4; i++) cs_pulse(6, 74);
    endtask

    bit finished = 0;

    initial begin
        cycles(5);
        check(ref_h == 1'b1, "R1", ref_h, 1);
        check(vreset_strobe == 1'b0, "R1", vreset_strobe, 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        cycles(5);

        // Separate-drive mode: various HD widths and two VD falls
        ref_tag = "R3";
        hd_pulse(10, 30); hd_pulse(1, 5); hd_pulse(2, 20);
        strobe_cnt = 0;
        ext_vd = 1'b0; cycles(20); ext_vd = 1'b1; cycles(10);
        ext_vd = 1'b0; cycles(3);  ext_vd = 1'b1; cycles(10);
        check(strobe_cnt == 2, "R7", strobe_cnt, 2);
        // composite input activity has no effect in this mode
        cs_pulse(40, 10);
        check(ref_h == 1'b1, "R2", ref_h, 1);

        // Switch to composite mode
        sel_composite = 1'b1;
        ref_tag = "R4";
        cycles(10);
        ext_hd = 1'b0; cycles(5);
        check(ref_h == 1'b1, "R2", ref_h, 1);
        ext_hd = 1'b1;
        strobe_cnt = 0;
        for (int i = 0; i < 3; i++) cs_pulse(6, 74);
        check(last_low_run == RD, "R5", last_low_run, RD);
        check(strobe_cnt == 0, "R8", strobe_cnt, 0);

        // A second fall inside the count window is ignored
        ref_tag = "R6";
        cs_pulse(3, 10); cs_pulse(3, 70);
        check(last_low_run == RD, "R6", last_low_run, RD);

        // Two fields of equalising and broad pulses
        ref_tag = "R4";
        strobe_cnt = 0;
        field();
        check(strobe_cnt == 1, "R9", strobe_cnt, 1);
        field();
        check(strobe_cnt == 2, "R9", strobe_cnt, 2);
        check(max_strobe_run == 1, "R10", max_strobe_run, 1);

        // Back to separate drives
        sel_composite = 1'b0;
        cycles(4);
        ref_tag = "R2";
        ext_hd = 1'b0; cycles(4);
        check(ref_h == 1'b0, "R2", ref_h, 0);
        ext_hd = 1'b1; cycles(4);
        check(ref_h == 1'b1, "R3", ref_h, 1);

        // Reset in mid-operation
        ext_hd = 1'b0; cycles(4);
        rst_n = 1'b0; cycles(1);
        check(ref_h == 1'b1, "R1", ref_h, 1);
        check(vreset_strobe == 1'b0, "R1", vreset_strobe, 0);
        compare_on = 1'b0;
        finished = 1;
    end

    initial begin
        for (int i = 0; i < 200000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule